// File: doc/BRIEF.md
# Indirect Paged Register Access Port

This block is a 16-bit host-bus slave with eight word ports. Most of its internal registers are not directly addressed. The host first writes a page offset into a pointer port. It then reads or writes the selected internal register through a page data port. A second data port, the high port, reaches the word two bytes above the pointer offset, so a 32-bit quantity can be read without moving the pointer.

The internal page holds the following registers:

- two read-only identification words;
- six configuration and control words, whose upper ten bits are writable;
- one read-only status word.

Two further ports hold transmit command and transmit length words; both are plain storage. The receive/transmit data ports and the interrupt status queue port read as zero in this block.

A small state machine accepts one host request at a time. It has three states:

- `ST_IDLE` accepts a request.
- `ST_RD_RESP` presents read data for one cycle.
- `ST_WR_APPLY` commits a latched write to its target.

Its transitions are:

- `IDLE_TO_RD`: a read is accepted.
- `IDLE_TO_WR`: a write is accepted.
- `RD_TO_IDLE` and `WR_TO_IDLE`: these are taken unconditionally one cycle later.

Top module: `pagereg_port`

## Requirements
- R1: After reset, a read of the pointer port returns 0x3000, `host_ready` is high, and each control word reads with its upper ten bits zero.
- R2: `host_port` is the byte offset divided by two. The ports are:
  - 0 and 1: data 0 at 0x00 and data 1 at 0x02;
  - 2: transmit command at 0x04;
  - 3: transmit length at 0x06;
  - 4: status queue at 0x08;
  - 5: pointer at 0x0A;
  - 6: page data at 0x0C;
  - 7: page data high at 0x0E.

  Ports 2 and 3 read back the last full 16-bit word written to them. Ports 0, 1 and 4 read 0x0000 and ignore writes.
- R3: The pointer always reads back with bits 15:12 = 0x3 and bit 0 = 0. Bits 11:1 hold the written value, which forms the word-aligned page offset.
- R4: Page offset 0x000 reads 0x630E. Page offset 0x002 reads the product code (default 0x0A00, with bits 7:0 and 15:13 zero). Both ignore writes.
- R5: The control words sit at page offsets 0x102, 0x104, 0x106, 0x10A, 0x112 and 0x116.
  - Bits 15:6 are writable and reset to zero.
  - Bits 5:0 always read a register number equal to the low offset byte plus one: 0x03, 0x05, 0x07, 0x0B, 0x13 and 0x17 respectively.
- R6: The status word at page offset 0x138 reads 0x0018 and ignores writes. Unmapped page offsets read 0x0000 and ignore writes.
- R7: The page data high port reads and writes the register at the pointer offset plus 2. The sum wraps within 12 bits.
- R8: Request acceptance and timing:
  - A request is accepted only when `host_ready` is high; requests while it is low are ignored.
  - `host_ready` drops for exactly one cycle after each accepted request.
  - A read returns data with `host_rvalid` high in the cycle after acceptance.
  - A write never raises `host_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req | input | 1 | Request strobe, taken when host_ready is high |
| host_we | input | 1 | 1 = write, 0 = read |
| host_port | input | 3 | Word port index (byte offset / 2) |
| host_wdata | input | 16 | Write data |
| host_ready | output | 1 | Block can accept a request this cycle |
| host_rvalid | output | 1 | Read data valid |
| host_rdata | output | 16 | Read data |

## Verification
A read accepted at clock edge k produces `host_rvalid` and `host_rdata` after edge k. The bench therefore samples them at the falling edge that follows edge k. A write accepted at edge k takes effect at edge k+1, when `ST_WR_APPLY` commits it. The bench waits for `host_ready` to return at the next falling edge before it issues any read that depends on that write. Requests are driven and outputs are sampled only at falling edges. The ignored-request case is injected precisely in the `ST_WR_APPLY` cycle and then observed through a later readback.

// File: rtl/pagereg_pkg.sv
package pagereg_pkg;

    localparam int DATA_W   = 16;
    localparam int OFF_W    = 12;
    localparam int PORT_W   = 3;
    localparam int NUM_REGS = 9;

    localparam logic [DATA_W-1:0] ID_WORD   = 16'h630E;
    localparam logic [DATA_W-1:0] CTL_WMASK = 16'hFFC0;
    localparam logic [3:0]        PTR_TAG   = 4'h3;

    typedef enum logic [PORT_W-1:0] {
        PORT_DATA0   = 3'd0,
        PORT_DATA1   = 3'd1,
        PORT_TXCMD   = 3'd2,
        PORT_TXLEN   = 3'd3,
        PORT_QUEUE   = 3'd4,
        PORT_PTR     = 3'd5,
        PORT_PDATA   = 3'd6,
        PORT_PDATAHI = 3'd7
    } port_e;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_RD_RESP  = 2'd1,
        ST_WR_APPLY = 2'd2
    } acc_state_e;

    typedef struct packed {
        logic [OFF_W-1:0]  offset;
        logic [DATA_W-1:0] wmask;
        logic [DATA_W-1:0] fixed;
    } page_entry_t;

    // Register number reported in bits 5:0 of control and status words
    function automatic logic [DATA_W-1:0] reg_number(logic [OFF_W-1:0] off);
        logic [7:0] low;
        low = off[7:0];
        if (low < 8'h20)
            return {8'h00, low + 8'h01};
        else
            return {8'h00, low - 8'h20};
    endfunction

    function automatic page_entry_t page_entry(int idx, logic [DATA_W-1:0] product);
        page_entry_t e;
        case (idx)
            0:       e = '{offset: 12'h000, wmask: '0, fixed: ID_WORD};
            1:       e = '{offset: 12'h002, wmask: '0, fixed: product};
            2:       e = '{offset: 12'h102, wmask: CTL_WMASK, fixed: reg_number(12'h102)};
            3:       e = '{offset: 12'h104, wmask: CTL_WMASK, fixed: reg_number(12'h104)};
            4:       e = '{offset: 12'h106, wmask: CTL_WMASK, fixed: reg_number(12'h106)};
            5:       e = '{offset: 12'h10A, wmask: CTL_WMASK, fixed: reg_number(12'h10A)};
            6:       e = '{offset: 12'h112, wmask: CTL_WMASK, fixed: reg_number(12'h112)};
            7:       e = '{offset: 12'h116, wmask: CTL_WMASK, fixed: reg_number(12'h116)};
            default: e = '{offset: 12'h138, wmask: '0, fixed: reg_number(12'h138)};
        endcase
        return e;
    endfunction

endpackage

// File: rtl/pagereg_pointer.sv
module pagereg_pointer
    import pagereg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic [OFF_W-1:0]  offset,
    output logic [DATA_W-1:0] readback
);
    localparam int STORE_W = OFF_W - 1;
    localparam int PAD_W   = DATA_W - OFF_W - 4;

    logic [STORE_W-1:0] word_sel_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            word_sel_q <= '0;
        else if (wr_en)
            word_sel_q <= wr_data[OFF_W-1:1];
    end

    always_comb begin
        offset = {word_sel_q, 1'b0};
        if (PAD_W > 0)
            readback = {PTR_TAG, {(DATA_W-OFF_W-4){1'b0}} , offset};
        else
            readback = {PTR_TAG, offset};
    end

endmodule

// File: rtl/pagereg_cell.sv
module pagereg_cell
    import pagereg_pkg::*;
#(
    parameter logic [OFF_W-1:0]  OFFSET = '0,
    parameter logic [DATA_W-1:0] WMASK  = '0,
    parameter logic [DATA_W-1:0] FIXED  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off_a,
    input  logic [OFF_W-1:0]  rd_off_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);
    logic [DATA_W-1:0] value;

    generate
        if (WMASK != '0) begin : g_writable
            logic [DATA_W-1:0] store_q;
            always_ff @(posedge clk) begin
                if (!rst_n)
                    store_q <= '0;
                else if (wr_en && (wr_off == OFFSET))
                    store_q <= wr_data & WMASK;
            end
            assign value = (store_q & WMASK) | (FIXED & ~WMASK);
        end else begin : g_fixed
            assign value = FIXED;
        end
    endgenerate

    assign rd_data_a = (rd_off_a == OFFSET) ? value : '0;
    assign rd_data_b = (rd_off_b == OFFSET) ? value : '0;

endmodule

// File: rtl/pagereg_file.sv
module pagereg_file
    import pagereg_pkg::*;
#(
    parameter logic [DATA_W-1:0] PRODUCT_CODE = 16'h0A00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  rd_off_a,
    input  logic [OFF_W-1:0]  rd_off_b,
    output logic [DATA_W-1:0] rd_data_a,
    output logic [DATA_W-1:0] rd_data_b
);
    logic [DATA_W-1:0] cell_a [NUM_REGS];
    logic [DATA_W-1:0] cell_b [NUM_REGS];

    generate
        for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
            localparam page_entry_t ENT = page_entry(i, PRODUCT_CODE);
            pagereg_cell #(
                .OFFSET (ENT.offset),
                .WMASK  (ENT.wmask),
                .FIXED  (ENT.fixed)
            ) u_cell (
                .clk       (clk),
                .rst_n     (rst_n),
                .wr_en     (wr_en),
                .wr_off    (wr_off),
                .wr_data   (wr_data),
                .rd_off_a  (rd_off_a),
                .rd_off_b  (rd_off_b),
                .rd_data_a (cell_a[i]),
                .rd_data_b (cell_b[i])
            );
        end
    endgenerate

    // Offsets are unique, so at most one cell drives a non-zero word
    always_comb begin
        rd_data_a = '0;
        rd_data_b = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            rd_data_a = rd_data_a | cell_a[i];
            rd_data_b = rd_data_b | cell_b[i];
        end
    end

endmodule

// File: rtl/pagereg_port.sv
module pagereg_port
    import pagereg_pkg::*;
#(
    parameter logic [DATA_W-1:0] PRODUCT_CODE = 16'h0A00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [PORT_W-1:0] host_port,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic              host_rvalid,
    output logic [DATA_W-1:0] host_rdata
);
    localparam logic [OFF_W-1:0] HI_STEP = OFF_W'(2);

    acc_state_e        state_q, state_d;
    logic              accept;
    port_e             req_port_q;
    logic [DATA_W-1:0] req_wdata_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] txcmd_q, txlen_q;

    logic [OFF_W-1:0]  ptr_off;
    logic [DATA_W-1:0] ptr_readback;
    logic [OFF_W-1:0]  hi_off;
    logic [DATA_W-1:0] page_lo, page_hi;
    logic [DATA_W-1:0] rd_mux;

    logic              ptr_wr, page_wr;
    logic [OFF_W-1:0]  page_wr_off;

    assign accept = host_req && (state_q == ST_IDLE);
    assign hi_off = ptr_off + HI_STEP;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept && host_we)
                    state_d = ST_WR_APPLY;   // IDLE_TO_WR
                else if (accept)
                    state_d = ST_RD_RESP;    // IDLE_TO_RD
            end
            ST_RD_RESP:  state_d = ST_IDLE;  // RD_TO_IDLE
            ST_WR_APPLY: state_d = ST_IDLE;  // WR_TO_IDLE
            default:     state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        host_ready  = (state_q == ST_IDLE);
        host_rvalid = (state_q == ST_RD_RESP);
        host_rdata  = host_rvalid ? rdata_q : '0;
    end

    // Request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_port_q  <= PORT_DATA0;
            req_wdata_q <= '0;
            rdata_q     <= '0;
        end else if (accept) begin
            req_port_q  <= port_e'(host_port);
            req_wdata_q <= host_wdata;
            if (!host_we)
                rdata_q <= rd_mux;
        end
    end

    // Read port decode
    always_comb begin
        unique case (port_e'(host_port))
            PORT_TXCMD:   rd_mux = txcmd_q;
            PORT_TXLEN:   rd_mux = txlen_q;
            PORT_PTR:     rd_mux = ptr_readback;
            PORT_PDATA:   rd_mux = page_lo;
            PORT_PDATAHI: rd_mux = page_hi;
            default:      rd_mux = '0;
        endcase
    end

    // Write commit in the apply state
    always_comb begin
        ptr_wr      = 1'b0;
        page_wr     = 1'b0;
        page_wr_off = ptr_off;
        if (state_q == ST_WR_APPLY) begin
            unique case (req_port_q)
                PORT_PTR:     ptr_wr = 1'b1;
                PORT_PDATA:   page_wr = 1'b1;
                PORT_PDATAHI: begin
                    page_wr     = 1'b1;
                    page_wr_off = hi_off;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            txcmd_q <= '0;
            txlen_q <= '0;
        end else if (state_q == ST_WR_APPLY) begin
            if (req_port_q == PORT_TXCMD) txcmd_q <= req_wdata_q;
            if (req_port_q == PORT_TXLEN) txlen_q <= req_wdata_q;
        end
    end

    pagereg_pointer u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (ptr_wr),
        .wr_data  (req_wdata_q),
        .offset   (ptr_off),
        .readback (ptr_readback)
    );

    pagereg_file #(
        .PRODUCT_CODE (PRODUCT_CODE)
    ) u_file (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (page_wr),
        .wr_off    (page_wr_off),
        .wr_data   (req_wdata_q),
        .rd_off_a  (ptr_off),
        .rd_off_b  (hi_off),
        .rd_data_a (page_lo),
        .rd_data_b (page_hi)
    );

endmodule

// File: rtl/pagereg_port_checker.sv
module pagereg_port_checker
    import pagereg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              host_req,
    input logic              host_we,
    input logic [PORT_W-1:0] host_port,
    input logic              host_ready,
    input logic              host_rvalid,
    input logic [DATA_W-1:0] host_rdata
);
    logic [PORT_W-1:0] last_port_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            last_port_q <= '0;
        else if (host_req && host_ready)
            last_port_q <= host_port;
    end

    assert_read_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready && !host_we) |=> host_rvalid);

    assert_ready_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready) |=> !host_ready);

    assert_write_no_resp_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (host_req && host_ready && host_we) |=> !host_rvalid);

    assert_ptr_tag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && last_port_q == PORT_PTR) |->
            (host_rdata[15:12] == PTR_TAG && host_rdata[0] == 1'b0));

    assert_quiet_ports_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rvalid && (last_port_q == PORT_DATA0 || last_port_q == PORT_DATA1 ||
                         last_port_q == PORT_QUEUE)) |-> (host_rdata == '0));

endmodule

bind pagereg_port pagereg_port_checker u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .host_req    (host_req),
    .host_we     (host_we),
    .host_port   (host_port),
    .host_ready  (host_ready),
    .host_rvalid (host_rvalid),
    .host_rdata  (host_rdata)
);

// File: tb/pagereg_port_bench.sv
module pagereg_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [2:0]  host_port = '0;
    logic [15:0] host_wdata = '0;
    logic        host_ready;
    logic        host_rvalid;
    logic [15:0] host_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // Bench model of the six control words (writable bits only)
    logic [15:0] ctl_model [6];

    always #5 clk = ~clk;

    pagereg_port u_pagereg_port (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_req    (host_req),
        .host_we     (host_we),
        .host_port   (host_port),
        .host_wdata  (host_wdata),
        .host_ready  (host_ready),
        .host_rvalid (host_rvalid),
        .host_rdata  (host_rdata)
    );

    function automatic logic [11:0] ctl_off(int i);
        case (i)
            0: return 12'h102;
            1: return 12'h104;
            2: return 12'h106;
            3: return 12'h10A;
            4: return 12'h112;
            default: return 12'h116;
        endcase
    endfunction

    function automatic logic [15:0] ctl_num(int i);
        case (i)
            0: return 16'h0003;
            1: return 16'h0005;
            2: return 16'h0007;
            3: return 16'h000B;
            4: return 16'h0013;
            default: return 16'h0017;
        endcase
    endfunction

    function automatic logic [15:0] page_expect(logic [11:0] off);
        if (off == 12'h000) return 16'h630E;
        if (off == 12'h002) return 16'h0A00;
        if (off == 12'h138) return 16'h0018;
        for (int i = 0; i < 6; i++)
            if (off == ctl_off(i)) return ctl_model[i] | ctl_num(i);
        return 16'h0000;
    endfunction

    task automatic check(string req, logic [15:0] got, logic [15:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%04h expected=%04h", req, got, exp);
        end
    endtask

    task automatic bus_write(logic [2:0] port, logic [15:0] data);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_port = port; host_wdata = data;
        @(negedge clk);
        host_req = 1'b0;
        @(negedge clk);
    endtask

    task automatic bus_read(logic [2:0] port, output logic [15:0] data);
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_we = 1'b0; host_port = port;
        @(negedge clk);
        host_req = 1'b0;
        check("R8 rvalid one cycle after read", {15'b0, host_rvalid}, 16'h0001);
        data = host_rdata;
        @(negedge clk);
    endtask

    task automatic page_read_check(string req, logic [11:0] off);
        logic [15:0] v;
        bus_write(3'd5, {4'h0, off});
        bus_read(3'd6, v);
        check(req, v, page_expect(off));
    endtask

    initial begin
        logic [15:0] v;
        logic [15:0] r;
        int idx;
        for (int i = 0; i < 6; i++) ctl_model[i] = 16'h0000;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        check("R1 ready after reset", {15'b0, host_ready}, 16'h0001);
        bus_read(3'd5, v);
        check("R1 pointer reset value", v, 16'h3000);
        for (int i = 0; i < 6; i++) page_read_check("R1 R5 control reset value", ctl_off(i));

        // R4 identification words and write immunity
        page_read_check("R4 registration word", 12'h000);
        page_read_check("R4 product code", 12'h002);
        bus_write(3'd6, 16'hFFFF);
        bus_read(3'd6, v);
        check("R4 product code ignores write", v, 16'h0A00);
        check("R4 product code zero bits", v & 16'hE0FF, 16'h0000);

        // R6 status and unmapped offsets
        bus_write(3'd5, 16'h0138);
        bus_write(3'd6, 16'h5555);
        bus_read(3'd6, v);
        check("R6 status word ignores write", v, 16'h0018);
        bus_write(3'd5, 16'h0200);
        bus_write(3'd6, 16'hABCD);
        bus_read(3'd6, v);
        check("R6 unmapped offset reads zero", v, 16'h0000);

        // R5 random write/readback of control words
        for (int n = 0; n < 40; n++) begin
            idx = int'($urandom_range(0, 5));
            r = 16'($urandom);
            bus_write(3'd5, {4'h0, ctl_off(idx)});
            bus_write(3'd6, r);
            ctl_model[idx] = r & 16'hFFC0;
            idx = int'($urandom_range(0, 5));
            page_read_check("R5 control readback", ctl_off(idx));
        end

        // R3 random pointer values
        for (int n = 0; n < 20; n++) begin
            r = 16'($urandom);
            bus_write(3'd5, r);
            bus_read(3'd5, v);
            check("R3 pointer readback", v, {4'h3, r[11:1], 1'b0});
        end
        bus_write(3'd5, 16'hF103);
        bus_read(3'd5, v);
        check("R3 pointer tag and alignment", v, 16'h3102);

        // R7 data high port
        bus_write(3'd5, 16'h0000);
        bus_read(3'd7, v);
        check("R7 high port at offset 0", v, 16'h0A00);
        bus_write(3'd5, 16'h0102);
        bus_write(3'd7, 16'h1234);
        ctl_model[1] = 16'h1234 & 16'hFFC0;
        bus_read(3'd7, v);
        check("R7 high port write/read", v, page_expect(12'h104));
        bus_read(3'd6, v);
        check("R7 low port unaffected", v, page_expect(12'h102));
        bus_write(3'd5, 16'h0FFE);
        bus_read(3'd7, v);
        check("R7 high port wraps to offset 0", v, 16'h630E);

        // R2 port map
        bus_write(3'd2, 16'hBEEF);
        bus_write(3'd3, 16'h05EA);
        bus_read(3'd2, v);
        check("R2 tx command readback", v, 16'hBEEF);
        bus_read(3'd3, v);
        check("R2 tx length readback", v, 16'h05EA);
        bus_write(3'd0, 16'h1111);
        bus_write(3'd1, 16'h2222);
        bus_write(3'd4, 16'h3333);
        bus_read(3'd0, v); check("R2 data0 reads zero", v, 16'h0000);
        bus_read(3'd1, v); check("R2 data1 reads zero", v, 16'h0000);
        bus_read(3'd4, v); check("R2 queue reads zero", v, 16'h0000);

        // R8 request while busy is ignored
        while (!host_ready) @(negedge clk);
        host_req = 1'b1; host_we = 1'b1; host_port = 3'd3; host_wdata = 16'h0111;
        @(negedge clk);
        check("R8 ready low after accept", {15'b0, host_ready}, 16'h0000);
        host_wdata = 16'h0999;   // still requesting during apply cycle
        @(negedge clk);
        host_req = 1'b0;
        @(negedge clk);
        bus_read(3'd3, v);
        check("R8 busy request ignored", v, 16'h0111);
        check("R8 ready back after read", {15'b0, host_ready}, 16'h0001);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule